// File: doc/BRIEF.md
# Burst-of-four quad-rate SRAM core

This block is a synthesizable device-side model of a synchronous SRAM that moves four data words per access over two separate, one-way data ports. A single address bus, sampled once per clock, carries both read and write requests. Each clock the core samples a read strobe, a write strobe and the address. At most one request is taken per clock. Two requests of the same kind may not be taken on back-to-back cycles, but a read and a write may follow one another directly.

Double-rate data movement is modelled as two words per clock on a bus of twice the word width. The word moved first sits in the low half. A write burst therefore takes its data in the request cycle and in the cycle after it. A read burst is returned over two cycles, after a fixed latency, with a valid flag. Each byte lane of a write word can be blocked, so that lane keeps its old content. Nine-bit lanes are used when the word width is a multiple of nine; an 8-bit word uses two 4-bit lanes. The storage is a small register array of `GROUPS` four-word groups. A request that breaks the issue rules is dropped and raises an error flag for one cycle.

Top module: `qdr_b4_sram`

## Requirements
- R1: While rst_ni is low, rvalid_o, proto_err_o and rdata_o are all zero. After reset every word of the array reads as zero.
- R2: A legal write request in cycle t (wr_req_i high, rd_req_i low) targets group addr_i[GRP_W-1:0]. Burst words 0 and 1 are taken from wdata_i[DATA_W-1:0] and wdata_i[2*DATA_W-1:DATA_W] in cycle t. Words 2 and 3 are taken from the same two halves in cycle t+1.
- R3: A legal read request in cycle t drives rvalid_o high in cycles t+RD_LAT and t+RD_LAT+1, and in no other cycle on its account. Words 0 (low half) and 1 (high half) come first, then words 2 and 3.
- R4: Bit w*LANES+l of wr_blk_i, when high, keeps lane l (bits l*LANE_W and up) of the word carried in half w. LANES is DATA_W/9 when DATA_W is a multiple of nine and DATA_W/4 otherwise, and LANE_W is DATA_W/LANES.
- R5: A read may be taken in the cycle right after a taken write, and a write right after a taken read. Both complete, and proto_err_o stays low after every legal request.
- R6: A read in the cycle right after a taken read, or a write right after a taken write, is dropped and raises proto_err_o in the next cycle. The wdata_i in that cycle still serves as words 2 and 3 of the earlier write.
- R7: rd_req_i and wr_req_i high in the same cycle drops both requests and raises proto_err_o in the next cycle.
- R8: Reads issued every other cycle give an unbroken rvalid_o stream.
- R9: rdata_o is all zero in every cycle where rvalid_o is low.
- R10: The address width follows the word width: 19 bits for words of 9 bits or fewer, 18 bits for 18-bit words and 17 bits for wider words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_req_i | input | 1 | Read request strobe |
| wr_req_i | input | 1 | Write request strobe |
| addr_i | input | ADDR_W (18) | Burst address, shared by reads and writes |
| wdata_i | input | 2*DATA_W (36) | Two write words per clock, first word in the low half |
| wr_blk_i | input | 2*LANES (4) | Lane blocking bits, one per lane of each word |
| rdata_o | output | 2*DATA_W (36) | Two read words per clock, first word in the low half |
| rvalid_o | output | 1 | High in the two data cycles of a read burst |
| proto_err_o | output | 1 | High the cycle after a dropped request |

## Verification
Each result is due a fixed number of cycles after its stimulus:
- An error flag is due one cycle after the offending request.
- The two halves of a read burst are due RD_LAT and RD_LAT+1 cycles after the read request.
- A write is observed through a later read of the same group.

When the bench drives a request it tags the expected data and flag with the cycle number they are due. A monitor samples on the falling edge of every cycle. It compares whatever is due in that cycle, and it fails any rvalid_o or proto_err_o seen in a cycle where nothing is due. Reads are never issued to a group whose write burst is still in flight, so each expected value depends only on the protocol rules.

// File: rtl/qdr_b4_pkg.sv
package qdr_b4_pkg;
  localparam int BURST_LEN = 4;

  function automatic int addr_w_for(input int dw);
    if (dw <= 9) return 19;
    else if (dw <= 18) return 18;
    else return 17;
  endfunction

  // nine-bit lanes when the word allows it, else nibble lanes
  function automatic int lanes_for(input int dw);
    if (dw % 9 == 0) return dw / 9;
    else return dw / 4;
  endfunction
endpackage

// File: rtl/qdr_b4_req_ctrl.sv
module qdr_b4_req_ctrl #(
  parameter int GRP_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_req_i,
  input  logic             wr_req_i,
  input  logic [GRP_W-1:0] grp_i,
  output logic             rd_acc_o,
  output logic             wr_acc_o,
  output logic             wr_ph2_o,
  output logic [GRP_W-1:0] wr_grp_o,
  output logic             err_o
);
  logic             rd_last_q;
  logic             wr_last_q;
  logic [GRP_W-1:0] wr_grp_q;
  logic             err_q;
  logic             dual;
  logic             err_d;

  assign dual     = rd_req_i & wr_req_i;
  assign rd_acc_o = rd_req_i & ~wr_req_i & ~rd_last_q;
  assign wr_acc_o = wr_req_i & ~rd_req_i & ~wr_last_q;
  assign err_d    = dual | (rd_req_i & rd_last_q) | (wr_req_i & wr_last_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_last_q <= 1'b0;
      wr_last_q <= 1'b0;
      wr_grp_q  <= '0;
      err_q     <= 1'b0;
    end else begin
      rd_last_q <= rd_acc_o;
      wr_last_q <= wr_acc_o;
      err_q     <= err_d;
      if (wr_acc_o) wr_grp_q <= grp_i;
    end
  end

  assign wr_ph2_o = wr_last_q;
  assign wr_grp_o = wr_grp_q;
  assign err_o    = err_q;
endmodule

// File: rtl/qdr_b4_array.sv
module qdr_b4_array import qdr_b4_pkg::*; #(
  parameter int DATA_W = 18,
  parameter int LANES  = 2,
  parameter int GROUPS = 16,
  localparam int GRP_W  = $clog2(GROUPS),
  localparam int LANE_W = DATA_W / LANES
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [GRP_W-1:0]    w_grp_i,
  input  logic                w_hi_i,
  input  logic [2*DATA_W-1:0] wdata_i,
  input  logic [2*LANES-1:0]  blk_i,
  input  logic [GRP_W-1:0]    r_grp_i,
  input  logic                r_hi_i,
  output logic [2*DATA_W-1:0] rdata_o
);
  logic [BURST_LEN-1:0][DATA_W-1:0] mem [GROUPS];
  logic [2*LANES-1:0] lane_we;

  for (genvar i = 0; i < 2*LANES; i++) begin : g_lane
    assign lane_we[i] = we_i & ~blk_i[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int g = 0; g < GROUPS; g++) mem[g] <= '0;
    end else begin
      for (int w = 0; w < 2; w++) begin
        for (int l = 0; l < LANES; l++) begin
          if (lane_we[w*LANES+l])
            mem[w_grp_i][{w_hi_i, 1'(w)}][l*LANE_W +: LANE_W]
              <= wdata_i[w*DATA_W + l*LANE_W +: LANE_W];
        end
      end
    end
  end

  assign rdata_o = {mem[r_grp_i][{r_hi_i, 1'b1}], mem[r_grp_i][{r_hi_i, 1'b0}]};
endmodule

// File: rtl/qdr_b4_rd_pipe.sv
module qdr_b4_rd_pipe #(
  parameter int DATA_W = 18,
  parameter int GRP_W  = 4,
  parameter int RD_LAT = 2,
  localparam int STG   = RD_LAT - 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                acc_i,
  input  logic [GRP_W-1:0]    grp_i,
  output logic [GRP_W-1:0]    arr_grp_o,
  output logic                arr_hi_o,
  input  logic [2*DATA_W-1:0] arr_data_i,
  output logic [2*DATA_W-1:0] rdata_o,
  output logic                rvalid_o
);
  logic [STG-1:0]      st_v;
  logic [GRP_W-1:0]    st_g [STG];
  logic                ph2_q;
  logic [GRP_W-1:0]    ph2_g_q;
  logic                head_v;
  logic [GRP_W-1:0]    head_g;
  logic                out_v;
  logic [2*DATA_W-1:0] rdata_q;
  logic                rvalid_q;

  assign head_v    = st_v[STG-1];
  assign head_g    = st_g[STG-1];
  // reads are at least two cycles apart, so head and second half never overlap
  assign arr_grp_o = ph2_q ? ph2_g_q : head_g;
  assign arr_hi_o  = ph2_q;
  assign out_v     = head_v | ph2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_v     <= '0;
      for (int i = 0; i < STG; i++) st_g[i] <= '0;
      ph2_q    <= 1'b0;
      ph2_g_q  <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      st_v[0] <= acc_i;
      st_g[0] <= grp_i;
      for (int i = 1; i < STG; i++) begin
        st_v[i] <= st_v[i-1];
        st_g[i] <= st_g[i-1];
      end
      ph2_q    <= head_v;
      ph2_g_q  <= head_g;
      rvalid_q <= out_v;
      rdata_q  <= out_v ? arr_data_i : '0;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
endmodule

// File: rtl/qdr_b4_sram.sv
module qdr_b4_sram import qdr_b4_pkg::*; #(
  parameter int DATA_W = 18,
  parameter int GROUPS = 16,
  parameter int RD_LAT = 2,
  localparam int ADDR_W = addr_w_for(DATA_W),
  localparam int LANES  = lanes_for(DATA_W)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rd_req_i,
  input  logic                wr_req_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [2*DATA_W-1:0] wdata_i,
  input  logic [2*LANES-1:0]  wr_blk_i,
  output logic [2*DATA_W-1:0] rdata_o,
  output logic                rvalid_o,
  output logic                proto_err_o
);
  localparam int GRP_W = $clog2(GROUPS);

  logic [GRP_W-1:0]    grp;
  logic                rd_acc;
  logic                wr_acc;
  logic                wr_ph2;
  logic [GRP_W-1:0]    wr_grp_q;
  logic                arr_we;
  logic [GRP_W-1:0]    arr_w_grp;
  logic [GRP_W-1:0]    arr_r_grp;
  logic                arr_r_hi;
  logic [2*DATA_W-1:0] arr_rdata;

  assign grp       = addr_i[GRP_W-1:0];
  assign arr_we    = wr_acc | wr_ph2;
  assign arr_w_grp = wr_ph2 ? wr_grp_q : grp;

  qdr_b4_req_ctrl #(.GRP_W(GRP_W)) i_req_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_req_i (rd_req_i),
    .wr_req_i (wr_req_i),
    .grp_i    (grp),
    .rd_acc_o (rd_acc),
    .wr_acc_o (wr_acc),
    .wr_ph2_o (wr_ph2),
    .wr_grp_o (wr_grp_q),
    .err_o    (proto_err_o)
  );

  qdr_b4_array #(.DATA_W(DATA_W), .LANES(LANES), .GROUPS(GROUPS)) i_array (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (arr_we),
    .w_grp_i (arr_w_grp),
    .w_hi_i  (wr_ph2),
    .wdata_i (wdata_i),
    .blk_i   (wr_blk_i),
    .r_grp_i (arr_r_grp),
    .r_hi_i  (arr_r_hi),
    .rdata_o (arr_rdata)
  );

  qdr_b4_rd_pipe #(.DATA_W(DATA_W), .GRP_W(GRP_W), .RD_LAT(RD_LAT)) i_rd_pipe (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .acc_i      (rd_acc),
    .grp_i      (grp),
    .arr_grp_o  (arr_r_grp),
    .arr_hi_o   (arr_r_hi),
    .arr_data_i (arr_rdata),
    .rdata_o    (rdata_o),
    .rvalid_o   (rvalid_o)
  );
endmodule

// File: rtl/qdr_b4_sram_chk.sv
module qdr_b4_sram_chk #(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 18,
  parameter int RD_LAT = 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                rd_req_i,
  input logic                wr_req_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [2*DATA_W-1:0] rdata_o,
  input logic                rvalid_o,
  input logic                proto_err_o
);
  logic            c_rd_last;
  logic            c_wr_last;
  logic [RD_LAT:0] pend;
  logic            c_rd_ok;
  logic            c_wr_ok;
  logic            c_bad;

  assign c_rd_ok = rd_req_i & ~wr_req_i & ~c_rd_last;
  assign c_wr_ok = wr_req_i & ~rd_req_i & ~c_wr_last;
  assign c_bad   = (rd_req_i & wr_req_i) | (rd_req_i & c_rd_last) | (wr_req_i & c_wr_last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c_rd_last <= 1'b0;
      c_wr_last <= 1'b0;
      pend      <= '0;
    end else begin
      c_rd_last <= c_rd_ok;
      c_wr_last <= c_wr_ok;
      pend      <= {pend[RD_LAT-1:0], c_rd_ok};
    end
  end

  AST_RD_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o == (pend[RD_LAT-1] | pend[RD_LAT])); // R3
  AST_DUAL_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i && wr_req_i) |=> proto_err_o); // R7
  AST_REPEAT_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_req_i && c_rd_last) || (wr_req_i && c_wr_last)) |=> proto_err_o); // R6
  AST_LEGAL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !c_bad |=> !proto_err_o); // R5
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rvalid_o |-> (rdata_o == '0)); // R9
  AST_ADDR_KNOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i || wr_req_i) |-> !$isunknown(addr_i)); // R2
endmodule

bind qdr_b4_sram qdr_b4_sram_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .RD_LAT(RD_LAT)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rd_req_i    (rd_req_i),
  .wr_req_i    (wr_req_i),
  .addr_i      (addr_i),
  .rdata_o     (rdata_o),
  .rvalid_o    (rvalid_o),
  .proto_err_o (proto_err_o)
);

// File: tb/test_qdr_b4_sram.sv
module test_qdr_b4_sram;
  localparam int DW = 18;
  localparam int LN = 2;
  localparam int LW = 9;
  localparam int GR = 16;
  localparam int RL = 2;
  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b1;
  logic          rd_req = 1'b0;
  logic          wr_req = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [2*DW-1:0] wdata = '0;
  logic [2*LN-1:0] wblk = '0;
  logic [2*DW-1:0] rdata;
  logic          rvalid;
  logic          perr;

  qdr_b4_sram #(.DATA_W(DW), .GROUPS(GR), .RD_LAT(RL)) i_qdr_b4_sram (
    .clk_i(clk), .rst_ni(rst_n), .rd_req_i(rd_req), .wr_req_i(wr_req),
    .addr_i(addr), .wdata_i(wdata), .wr_blk_i(wblk),
    .rdata_o(rdata), .rvalid_o(rvalid), .proto_err_o(perr)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  bit mon_on = 1'b0;

  typedef struct {
    logic [2*DW-1:0] d;
    int              due;
    string           tag;
  } exp_t;
  exp_t  q[$];
  string err_exp[int];

  logic [DW-1:0] mdl [GR][4];
  bit last_rd = 1'b0;
  bit last_wr = 1'b0;
  bit wpend = 1'b0;
  int wpend_g = 0;

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic apply(int g, int hi, logic [2*DW-1:0] wd, logic [2*LN-1:0] b);
    for (int w = 0; w < 2; w++)
      for (int l = 0; l < LN; l++)
        if (!b[w*LN+l]) mdl[g][hi*2+w][l*LW +: LW] = wd[w*DW + l*LW +: LW];
  endtask

  // one cycle of stimulus plus the protocol model
  task automatic step(bit rd, bit wr, int g, logic [2*DW-1:0] wd, logic [2*LN-1:0] b, string tag);
    bit err, racc, wacc;
    @(posedge clk);
    #1;
    rd_req = rd; wr_req = wr; addr = AW'(g); wdata = wd; wblk = b;
    if (wpend) apply(wpend_g, 1, wd, b);
    err  = (rd && wr) || (rd && last_rd) || (wr && last_wr);
    racc = rd && !wr && !last_rd;
    wacc = wr && !rd && !last_wr;
    if (err) err_exp[cyc+1] = tag;
    if (wacc) apply(g, 0, wd, b);
    if (racc) begin
      q.push_back('{{mdl[g][1], mdl[g][0]}, cyc + RL, tag});
      q.push_back('{{mdl[g][3], mdl[g][2]}, cyc + RL + 1, tag});
    end
    last_rd = racc;
    last_wr = wacc;
    wpend   = wacc;
    wpend_g = g;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 0, '0, '0, "");
  endtask

  function automatic logic [2*DW-1:0] rnd();
    return (2*DW)'({$urandom(), $urandom()});
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // monitor: compare everything due in this cycle
  always @(negedge clk) begin
    if (mon_on && !done) begin
      if (q.size() > 0 && q[0].due == cyc) begin
        chk(rvalid && rdata == q[0].d, q[0].tag, "read half",
            64'({rvalid, rdata}), 64'({1'b1, q[0].d}));
        void'(q.pop_front());
      end else begin
        chk(!rvalid && rdata == '0, "R9", "idle output (rvalid/rdata)",
            64'({rvalid, rdata}), 64'(0));
      end
      if (err_exp.exists(cyc)) begin
        chk(perr, err_exp[cyc], "proto_err", 64'(perr), 64'(1));
        err_exp.delete(cyc);
      end else if (perr) begin
        chk(1'b0, "R5", "unexpected proto_err", 64'(1), 64'(0));
      end
    end
  end

  initial begin
    for (int g = 0; g < GR; g++)
      for (int i = 0; i < 4; i++) mdl[g][i] = '0;
    #5 rst_n = 1'b0;
    #1;
    chk(rvalid == 1'b0, "R1", "rvalid in reset", 64'(rvalid), 64'(0));
    chk(perr == 1'b0, "R1", "proto_err in reset", 64'(perr), 64'(0));
    chk(rdata == '0, "R1", "rdata in reset", 64'(rdata), 64'(0));
    chk($bits(i_qdr_b4_sram.addr_i) == 18, "R10", "address width",
        64'($bits(i_qdr_b4_sram.addr_i)), 64'(18));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    mon_on = 1'b1;
    idle(2);

    // R1: unwritten group reads zero
    step(1, 0, 5, '0, '0, "R1"); idle(4);

    // R2 / R3: plain write then read
    step(0, 1, 1, rnd(), '0, "R2"); step(0, 0, 0, rnd(), '0, "R2"); idle(1);
    step(1, 0, 1, '0, '0, "R2"); idle(4);
    step(1, 0, 1, '0, '0, "R3"); idle(4);

    // R4: lane blocking
    step(0, 1, 2, rnd(), '0, "R4"); step(0, 0, 0, rnd(), '0, "R4"); idle(1);
    step(0, 1, 2, rnd(), 4'b1001, "R4"); step(0, 0, 0, rnd(), 4'b0110, "R4"); idle(1);
    step(1, 0, 2, '0, '0, "R4"); idle(4);
    step(0, 1, 2, rnd(), 4'b1111, "R4"); step(0, 0, 0, rnd(), 4'b1111, "R4"); idle(1);
    step(1, 0, 2, '0, '0, "R4"); idle(4);

    // R5: interleaved write and read
    step(0, 1, 3, rnd(), '0, "R5"); step(1, 0, 1, rnd(), '0, "R5");
    step(0, 1, 4, rnd(), 4'b0100, "R5"); step(1, 0, 2, rnd(), '0, "R5");
    step(0, 1, 5, rnd(), '0, "R5"); step(0, 0, 0, rnd(), 4'b0010, "R5"); idle(1);
    step(1, 0, 3, '0, '0, "R5"); step(0, 0, 0, '0, '0, "R5");
    step(1, 0, 4, '0, '0, "R5"); step(0, 0, 0, '0, '0, "R5");
    step(1, 0, 5, '0, '0, "R5"); idle(4);

    // R8: reads every other cycle
    step(1, 0, 1, '0, '0, "R8"); idle(1);
    step(1, 0, 2, '0, '0, "R8"); idle(1);
    step(1, 0, 3, '0, '0, "R8"); idle(4);

    // R6: same kind back to back
    step(1, 0, 1, '0, '0, "R6"); step(1, 0, 2, '0, '0, "R6"); idle(4);
    step(0, 1, 6, rnd(), '0, "R6"); step(0, 1, 7, rnd(), '0, "R6"); idle(1);
    step(1, 0, 6, '0, '0, "R6"); idle(1);
    step(1, 0, 7, '0, '0, "R6"); idle(4);

    // R7: both requests in one cycle
    step(1, 1, 8, rnd(), '0, "R7"); idle(1);
    step(1, 0, 8, '0, '0, "R7"); idle(4);

    // mixed traffic: reads from low groups, writes to high groups
    for (int i = 0; i < 120; i++) begin
      bit r, w;
      int g;
      r = ($urandom() % 3) == 0;
      w = ($urandom() % 3) == 0;
      g = (r && !w) ? int'($urandom() % 8) : 8 + int'($urandom() % 8);
      step(r, w, g, rnd(), (2*LN)'($urandom()), (r && w) ? "R7" : (r ? "R5" : "R6"));
    end
    idle(1);
    for (int g = 8; g < GR; g++) begin
      step(1, 0, g, '0, '0, "R2"); idle(1);
    end
    idle(6);
    chk(q.size() == 0, "R3", "read bursts left undelivered", 64'(q.size()), 64'(0));
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      summary();
      $finish;
    end
  end
endmodule